// File: doc/BRIEF.md
# SPI Single-Word Register Access Front End

This block is the slave end of a serial link for a peripheral whose registers are one byte wide. Each chip-select window carries exactly one 16-bit word in SPI mode 0. The serial inputs are resynchronised into the system clock domain, where the block takes the word apart and turns it into either a register write or a register read request. Both are presented to a separate register bank as an address, write data and one-cycle strobes.

The high byte of the incoming word is the address byte. Its top bit selects a write, and its low seven bits name the register. The low byte is the data byte. When the write flag is clear, bit 7 of the data byte asks for the register contents. The value read is captured during the strobe cycle and shifted out on MISO in the next chip-select window, zero-extended into a 14-bit reply field. A window with any number of clocks other than 16 is thrown away. The sampling clock must run at least about four times faster than SCLK, because every serial edge is detected after synchronisation.

Top module: `spi_regif`

## Requirements
- R1: MOSI is sampled on rising SCLK edges while CS_n is low, most significant bit first, so the first bit clocked in becomes frame bit 15.
- R2: A complete frame with bit 15 set produces one single-cycle `reg_wr` after CS_n rises, with `reg_addr` equal to frame bits 14:8 and `reg_wdata` equal to frame bits 7:0. This holds even when bit 7 of the data byte is also set.
- R3: A complete frame with bit 15 clear and bit 7 set produces one single-cycle `reg_rd` after CS_n rises, with `reg_addr` equal to frame bits 14:8. The value on `reg_rdata` in that cycle is kept as the pending reply.
- R4: During the next chip-select window, MISO shifts out the pending reply MSB first. The register value sits in bits 7:0, reply bits 15:8 are zero, and MISO changes only on falling SCLK edges or at the start of the window.
- R5: A complete frame that is not a read request sets the pending reply to zero.
- R6: A window that ends after fewer than 16 rising SCLK edges is discarded. It issues no strobe and leaves the pending reply unchanged.
- R7: A window with more than 16 rising SCLK edges is discarded in the same way as a short one.
- R8: After reset, MISO and both strobes are low and the pending reply is zero.
- R9: `reg_wr` and `reg_rd` are never high in the same cycle.
- R10: MISO is low whenever CS_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low, one word per window |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial reply data |
| reg_addr | output | 7 | Register address from frame bits 14:8 |
| reg_wdata | output | 8 | Write data from frame bits 7:0 |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register value, sampled while `reg_rd` is high |

## Verification
The assertions check on every cycle that the strobes last a single cycle and never coincide. They also check that a write strobe only follows a cycle in which chip select was seen high, and that the outgoing shift register holds still except at a falling edge or at the start of a window. Only the bench scenarios can show the rest: that bits land at the right positions, that a read's value comes back one window later, zero-extended, and that windows that are too short or too long leave both the register contents and the pending reply untouched.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
   localparam int FRAME_W = 16;
   localparam int ADDR_W  = 7;
   localparam int DATA_W  = 8;

   // Incoming word layout: write flag, register index, data byte.
   // Bit 7 of the data byte doubles as the read-request flag.
   typedef struct packed {
      logic              wr_flag;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } frame_t;

   localparam int RD_FLAG_POS = DATA_W - 1;
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
   parameter int           WIDTH   = 1,
   parameter int           STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_regif_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      end else begin
         chain_q[0] <= din;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_regif_shift.sv
module spi_regif_shift
   import spi_regif_pkg::*;
#(
   parameter int FW = FRAME_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk_s,
   input  logic          csn_s,
   input  logic          mosi_s,
   input  logic [FW-1:0] reply_word,
   output logic          miso,
   output logic          done,
   output logic [FW-1:0] rx_word
);
   localparam int CNT_MAX = FW + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (FW < 2) begin : g_bad_fw
      $error("spi_regif_shift: frame width too small");
   end

   logic             sclk_q, csn_q;
   logic [CNT_W-1:0] cnt_q;
   logic [FW-1:0]    rx_q, tx_q;
   logic             start_evt, stop_evt, rise_evt, fall_evt;

   assign start_evt = csn_q & ~csn_s;
   assign stop_evt  = ~csn_q & csn_s;
   assign rise_evt  = ~csn_s & sclk_s & ~sclk_q;
   assign fall_evt  = ~csn_s & ~sclk_s & sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
         cnt_q  <= '0;
         rx_q   <= '0;
         tx_q   <= '0;
      end else begin
         sclk_q <= sclk_s;
         csn_q  <= csn_s;
         if (start_evt) begin
            cnt_q <= '0;
            tx_q  <= reply_word;
         end else begin
            if (rise_evt) begin
               rx_q <= {rx_q[FW-2:0], mosi_s};
               if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
            if (fall_evt) tx_q <= {tx_q[FW-2:0], 1'b0};
         end
      end
   end

   assign done    = stop_evt && (cnt_q == CNT_W'(FW));
   assign rx_word = rx_q;
   assign miso    = csn_s ? 1'b0 : tx_q[FW-1];

   assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn_s && !fall_evt && !start_evt) |=> $stable(tx_q));
endmodule

// File: rtl/spi_regif_decode.sv
module spi_regif_decode
   import spi_regif_pkg::*;
#(
   parameter int REPLY_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done,
   input  logic [FRAME_W-1:0] rx_word,
   input  logic [DATA_W-1:0]  reg_rdata,
   output logic [ADDR_W-1:0]  reg_addr,
   output logic [DATA_W-1:0]  reg_wdata,
   output logic               reg_wr,
   output logic               reg_rd,
   output logic [FRAME_W-1:0] reply_word
);
   if (REPLY_W < DATA_W || REPLY_W > FRAME_W) begin : g_bad_reply
      $error("spi_regif_decode: REPLY_W out of range");
   end

   frame_t             frm;
   logic [REPLY_W-1:0] reply_q;
   logic [REPLY_W-1:0] rdata_ext;

   assign frm = frame_t'(rx_word);

   if (REPLY_W == DATA_W) begin : g_ext_none
      assign rdata_ext = reg_rdata;
   end else begin : g_ext_zero
      assign rdata_ext = {{(REPLY_W-DATA_W){1'b0}}, reg_rdata};
   end

   if (REPLY_W == FRAME_W) begin : g_rep_full
      assign reply_word = reply_q;
   end else begin : g_rep_pad
      assign reply_word = {{(FRAME_W-REPLY_W){1'b0}}, reply_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
         reply_q   <= '0;
      end else begin
         reg_wr <= done & frm.wr_flag;
         reg_rd <= done & ~frm.wr_flag & frm.data[RD_FLAG_POS];
         if (done) begin
            reg_addr  <= frm.addr;
            reg_wdata <= frm.data;
         end
         if (reg_rd) begin
            reply_q <= rdata_ext;
         end else if (done && !(~frm.wr_flag & frm.data[RD_FLAG_POS])) begin
            reply_q <= '0;
         end
      end
   end

   assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));
endmodule

// File: rtl/spi_regif.sv
module spi_regif
   import spi_regif_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REPLY_W     = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);
   logic [2:0]         pins_s;
   logic               sclk_s, csn_s, mosi_s;
   logic               done;
   logic [FRAME_W-1:0] rx_word, reply_word;

   spi_regif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .din ({sclk, cs_n, mosi}), .dout (pins_s)
   );
   assign sclk_s = pins_s[2];
   assign csn_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   spi_regif_shift #(.FW(FRAME_W)) u_shift (
      .clk (clk), .rst_n (rst_n),
      .sclk_s (sclk_s), .csn_s (csn_s), .mosi_s (mosi_s),
      .reply_word (reply_word), .miso (miso),
      .done (done), .rx_word (rx_word)
   );

   spi_regif_decode #(.REPLY_W(REPLY_W)) u_dec (
      .clk (clk), .rst_n (rst_n),
      .done (done), .rx_word (rx_word), .reg_rdata (reg_rdata),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_wr (reg_wr), .reg_rd (reg_rd), .reply_word (reply_word)
   );

   assert_wr_after_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $past(csn_s));
   assert_rd_after_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> $past(csn_s));
endmodule

// File: tb/sim_spi_regif.sv
module sim_spi_regif;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic       reg_wr, reg_rd;

   logic [7:0] mem [128];
   int         wr_cnt = 0, rd_cnt = 0;
   int         total = 0, bad = 0;
   logic [15:0] got;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_regif u0 (
      .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
      .miso (miso), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_rdata (reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) begin
      if (reg_wr) begin
         mem[reg_addr] <= reg_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One chip-select window with nclk rising edges; returns MISO bits.
   task automatic xfer(input logic [15:0] word, input int nclk, output logic [15:0] rep);
      rep = '0;
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < nclk; i++) begin
         mosi = (i < 16) ? word[15-i] : 1'b0;
         wait_clk(HALF);
         if (i < 16) rep[15-i] = miso;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(3 * HALF);
   endtask

   task automatic t_reset;
      chk("R8 miso", miso, 0);
      chk("R8 reg_wr", reg_wr, 0);
      chk("R8 reg_rd", reg_rd, 0);
      xfer(16'h0000, 16, got);
      chk("R8 pending reply zero", got, 16'h0000);
      chk("R10 miso idle", miso, 0);
   endtask

   task automatic t_write(input logic [6:0] a, input logic [7:0] d);
      int w0 = wr_cnt, r0 = rd_cnt;
      xfer({1'b1, a, d}, 16, got);
      chk("R2 write count", wr_cnt - w0, 1);
      chk("R9 no read on write", rd_cnt - r0, 0);
      chk("R1 R2 stored data", mem[a], d);
   endtask

   task automatic t_read_back(input logic [6:0] a, input logic [7:0] exp);
      int r0 = rd_cnt;
      xfer({1'b0, a, 8'h80}, 16, got);
      chk("R3 read count", rd_cnt - r0, 1);
      xfer(16'h0000, 16, got);
      chk("R4 reply word", got, {8'h00, exp});
      xfer(16'h0000, 16, got);
      chk("R5 reply after noop", got, 16'h0000);
   endtask

   task automatic t_write_with_rdflag;
      int w0 = wr_cnt, r0 = rd_cnt;
      xfer({1'b0, 7'h10, 8'h80}, 16, got);
      xfer({1'b1, 7'h11, 8'h80}, 16, got);
      chk("R2 write with bit7 data", mem[7'h11], 8'h80);
      chk("R2 write count", wr_cnt - w0, 1);
      chk("R3 read count", rd_cnt - r0, 1);
      xfer(16'h0000, 16, got);
      chk("R5 reply after write", got, 16'h0000);
   endtask

   task automatic t_short;
      int w0 = wr_cnt, r0 = rd_cnt;
      xfer({1'b0, 7'h05, 8'h80}, 16, got);
      xfer({1'b1, 7'h05, 8'hFF}, 8, got);
      chk("R6 no write short", wr_cnt - w0, 0);
      chk("R6 data kept", mem[7'h05], 8'h3C);
      xfer(16'h0000, 16, got);
      chk("R6 reply kept", got, 16'h003C);
      chk("R6 reads", rd_cnt - r0, 1);
   endtask

   task automatic t_long;
      int w0 = wr_cnt, r0 = rd_cnt;
      xfer({1'b0, 7'h7F, 8'h80}, 16, got);
      xfer({1'b1, 7'h06, 8'h11}, 17, got);
      chk("R7 no write long", wr_cnt - w0, 0);
      chk("R7 reg untouched", mem[7'h06], 8'h00);
      xfer({1'b0, 7'h06, 8'h80}, 18, got);
      chk("R7 no read long", rd_cnt - r0, 1);
      xfer(16'h0000, 16, got);
      chk("R7 reply kept", got, 16'h00A5);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 8'h00;
      wait_clk(5);
      t_reset;
      rst_n = 1'b1;
      wait_clk(5);
      t_reset;
      t_write(7'h05, 8'h3C);
      t_write(7'h7F, 8'hA5);
      t_write(7'h00, 8'hFF);
      t_read_back(7'h05, 8'h3C);
      t_read_back(7'h7F, 8'hA5);
      t_read_back(7'h00, 8'hFF);
      t_write_with_rdflag;
      t_short;
      t_long;
      chk("R10 miso idle end", miso, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule